// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation-buffer miss with one memory read. A miss request brings a virtual page number and an access type (read or write). The walker takes the table base address, adds the page number scaled by the entry size to get the address of the one entry that maps the page, and issues a single word read on a request/ready memory port. When the returned entry is marked resident, the walker sends a refill record back to the translation buffer. The record holds the page number, the physical page number and the write-permission bit. When the entry is not resident, the walker raises a page-fault exception instead, and that exception carries the page-aligned virtual address and the access type.

The table is flat and indexed directly by the virtual page number. Each entry is one 32-bit word. Only supervisor-mode software can move the table base. The walker handles one miss at a time. It stops offering acceptance from the moment a miss is taken until its result pulse has been given.

Top module: `pt_walker`

## Requirements
- R1: After reset, `missReady` is 1 and `memReqValid`, `refillValid` and `faultValid` are 0. The table base equals the `BASE_RESET` parameter, which is 0 by default.
- R2: A miss is taken on a clock edge where `missValid` and `missReady` are both 1. `missReady` is 1 only while no walk is in progress. Miss requests presented during a walk are ignored, and their page numbers and access types never show up on any output.
- R3: In the cycle after a miss is taken, `memReqValid` is 1 and `memReqAddr` equals (base + page number × 4) modulo 2^32. Both hold steady until an edge where `memReqReady` is 1.
- R4: The table base takes `baseWrData` only on an edge where `baseWrEn` and `supervisor` are both 1. A write with `supervisor` at 0 is ignored, and the next walk still uses the old base.
- R5: The base used by a walk is the one in force when the miss is taken. A base write during the walk changes only later walks.
- R6: `memRspValid` counts only after the read request has been handshaken. A response that arrives before then is ignored.
- R7: If bit 31 (valid) of the returned entry is 1, `refillValid` pulses for exactly one cycle, in the cycle after the response. During that pulse, `refillPpn` = entry bits [17:0], `refillWritable` = entry bit 30 and `refillVpn` = the taken page number.
- R8: If bit 31 of the returned entry is 0, `faultValid` pulses for exactly one cycle, in the cycle after the response, and no refill is given. During that pulse, `faultVaddr` = {page number, 12 zero bits} and `faultIsWrite` = the taken access type (1 = write).
- R9: In the cycle after a refill or fault pulse, `missReady` is 1 again, so walks can follow back to back.
- R10: `refillValid` and `faultValid` are never 1 together, and `memReqValid` is 0 during either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supervisor | input | 1 | Privilege level of the current writer; 1 = supervisor |
| baseWrEn | input | 1 | Request to load the table base |
| baseWrData | input | 32 | New table base address |
| missValid | input | 1 | Miss request present |
| missVpn | input | 20 | Virtual page number of the miss |
| missIsWrite | input | 1 | Access type of the miss; 1 = write |
| missReady | output | 1 | Walker idle and able to take a miss |
| memReqValid | output | 1 | Entry read request |
| memReqAddr | output | 32 | Byte address of the entry |
| memReqReady | input | 1 | Memory takes the read request |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Returned table entry |
| refillValid | output | 1 | One-cycle refill pulse |
| refillVpn | output | 20 | Page number being refilled |
| refillPpn | output | 18 | Physical page number |
| refillWritable | output | 1 | Write permission of the page |
| faultValid | output | 1 | One-cycle page-fault pulse |
| faultVaddr | output | 32 | Page-aligned faulting virtual address |
| faultIsWrite | output | 1 | Access type of the faulting miss |

## Verification
The bench builds the walker with its default parameters: 32-bit virtual and memory addresses, 4 KB pages, 18-bit physical page numbers and a zero base at reset. With these widths, a base near the top of the address space combined with the all-ones page number makes the entry address wrap. That sum is checked exactly. The widths also let random page numbers and entries cover both values of the valid and write bits. Stalled memory handshakes, early responses, foreign misses and base writes during a walk are all mixed into these runs.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    WALK_IDLE,
    WALK_REQ,
    WALK_WAIT,
    WALK_DONE,
    WALK_FAULT
  } walkState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureMiss;
    logic capturePte;
  } walkStrobe_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        pteValid,
  output walkStrobe_t strobe,
  output logic        missReady,
  output logic        memReqValid,
  output logic        refillValid,
  output logic        faultValid
);

  walkState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      WALK_IDLE:  if (missValid)   stateNext = WALK_REQ;
      WALK_REQ:   if (memReqReady) stateNext = WALK_WAIT;
      WALK_WAIT:  if (memRspValid) stateNext = pteValid ? WALK_DONE : WALK_FAULT;
      WALK_DONE:  stateNext = WALK_IDLE;
      WALK_FAULT: stateNext = WALK_IDLE;
      default:    stateNext = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WALK_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.captureMiss = (state == WALK_IDLE) && missValid;
    strobe.capturePte  = (state == WALK_WAIT) && memRspValid;
  end

  assign missReady   = (state == WALK_IDLE);
  assign memReqValid = (state == WALK_REQ);
  assign refillValid = (state == WALK_DONE);
  assign faultValid  = (state == WALK_FAULT);

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned OFS_W     = 12,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned PPN_W     = 18,
  parameter int unsigned VALID_BIT = 31,
  parameter int unsigned WRITE_BIT = 30,
  parameter logic [ADDR_W-1:0] BASE_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic              supervisor,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [VA_W-OFS_W-1:0] missVpn,
  input  logic              missIsWrite,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              pteValid,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [VA_W-OFS_W-1:0] refillVpn,
  output logic [PPN_W-1:0]  refillPpn,
  output logic              refillWritable,
  output logic [VA_W-1:0]   faultVaddr,
  output logic              faultIsWrite,
  output logic [ADDR_W-1:0] baseReg
);

  localparam int unsigned VPN_W     = VA_W - OFS_W;
  localparam int unsigned PTE_BYTES = PTE_W / 8;
  localparam int unsigned PTE_SHIFT = $clog2(PTE_BYTES);
  localparam int unsigned PAD_W     = ADDR_W - VPN_W - PTE_SHIFT;

  logic [VPN_W-1:0]  vpnReg;
  logic              isWriteReg;
  logic [ADDR_W-1:0] addrReg;
  logic [PPN_W-1:0]  ppnReg;
  logic              writableReg;
  logic [ADDR_W-1:0] entryOffset;
  logic              pteUnused;

  // Scaled page number, zero-extended to the address width
  generate
    if (PAD_W > 0) begin : g_pad
      assign entryOffset = {{PAD_W{1'b0}}, missVpn, {PTE_SHIFT{1'b0}}};
    end else begin : g_nopad
      assign entryOffset = ADDR_W'({missVpn, {PTE_SHIFT{1'b0}}});
    end
  endgenerate

  // Table base: supervisor-only writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         baseReg <= BASE_RESET;
    else if (baseWrEn && supervisor)   baseReg <= baseWrData;
  end

  // Miss capture: address formed with the base in force at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpnReg     <= '0;
      isWriteReg <= 1'b0;
      addrReg    <= '0;
    end else if (strobe.captureMiss) begin
      vpnReg     <= missVpn;
      isWriteReg <= missIsWrite;
      addrReg    <= baseReg + entryOffset;
    end
  end

  // Entry capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ppnReg      <= '0;
      writableReg <= 1'b0;
    end else if (strobe.capturePte) begin
      ppnReg      <= memRspData[PPN_W-1:0];
      writableReg <= memRspData[WRITE_BIT];
    end
  end

  assign pteValid       = memRspData[VALID_BIT];
  assign pteUnused      = ^memRspData;
  assign memReqAddr     = addrReg;
  assign refillVpn      = vpnReg;
  assign refillPpn      = ppnReg;
  assign refillWritable = writableReg;
  assign faultVaddr     = {vpnReg, {OFS_W{1'b0}}};
  assign faultIsWrite   = isWriteReg;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned OFS_W     = 12,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned PPN_W     = 18,
  parameter int unsigned VALID_BIT = 31,
  parameter int unsigned WRITE_BIT = 30,
  parameter logic [ADDR_W-1:0] BASE_RESET = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  supervisor,
  input  logic                  baseWrEn,
  input  logic [ADDR_W-1:0]     baseWrData,
  input  logic                  missValid,
  input  logic [VA_W-OFS_W-1:0] missVpn,
  input  logic                  missIsWrite,
  output logic                  missReady,
  output logic                  memReqValid,
  output logic [ADDR_W-1:0]     memReqAddr,
  input  logic                  memReqReady,
  input  logic                  memRspValid,
  input  logic [PTE_W-1:0]      memRspData,
  output logic                  refillValid,
  output logic [VA_W-OFS_W-1:0] refillVpn,
  output logic [PPN_W-1:0]      refillPpn,
  output logic                  refillWritable,
  output logic                  faultValid,
  output logic [VA_W-1:0]       faultVaddr,
  output logic                  faultIsWrite
);

  walkStrobe_t       strobe;
  logic              pteValid;
  logic [ADDR_W-1:0] baseReg;

  pt_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .pteValid    (pteValid),
    .strobe      (strobe),
    .missReady   (missReady),
    .memReqValid (memReqValid),
    .refillValid (refillValid),
    .faultValid  (faultValid)
  );

  pt_walker_dp #(
    .VA_W(VA_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .PTE_W(PTE_W),
    .PPN_W(PPN_W), .VALID_BIT(VALID_BIT), .WRITE_BIT(WRITE_BIT),
    .BASE_RESET(BASE_RESET)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .supervisor     (supervisor),
    .baseWrEn       (baseWrEn),
    .baseWrData     (baseWrData),
    .missVpn        (missVpn),
    .missIsWrite    (missIsWrite),
    .memRspData     (memRspData),
    .pteValid       (pteValid),
    .memReqAddr     (memReqAddr),
    .refillVpn      (refillVpn),
    .refillPpn      (refillPpn),
    .refillWritable (refillWritable),
    .faultVaddr     (faultVaddr),
    .faultIsWrite   (faultIsWrite),
    .baseReg        (baseReg)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              supervisor,
  input logic              baseWrEn,
  input logic              missValid,
  input logic              missReady,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memReqReady,
  input logic              memRspValid,
  input logic              refillValid,
  input logic              faultValid,
  input logic [ADDR_W-1:0] baseReg
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    missReady |-> (!memReqValid && !refillValid && !faultValid)); // R2

  AST_ACCEPT_TO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> memReqValid); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))); // R3

  AST_BASE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    !(baseWrEn && supervisor) |=> $stable(baseReg)); // R4

  AST_REFILL_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    refillValid |-> $past(memRspValid)); // R7

  AST_FAULT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $past(memRspValid)); // R8

  AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    refillValid |=> (!refillValid && missReady)); // R9

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> (!faultValid && missReady)); // R9

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(refillValid && faultValid) && !((refillValid || faultValid) && memReqValid)); // R10

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .supervisor  (supervisor),
  .baseWrEn    (baseWrEn),
  .missValid   (missValid),
  .missReady   (missReady),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memReqReady (memReqReady),
  .memRspValid (memRspValid),
  .refillValid (refillValid),
  .faultValid  (faultValid),
  .baseReg     (baseReg)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        supervisor = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        missValid = 1'b0;
  logic [19:0] missVpn = '0;
  logic        missIsWrite = 1'b0;
  logic        missReady;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        refillValid;
  logic [19:0] refillVpn;
  logic [17:0] refillPpn;
  logic        refillWritable;
  logic        faultValid;
  logic [31:0] faultVaddr;
  logic        faultIsWrite;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .supervisor(supervisor), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .missValid(missValid), .missVpn(missVpn),
    .missIsWrite(missIsWrite), .missReady(missReady), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .refillValid(refillValid), .refillVpn(refillVpn),
    .refillPpn(refillPpn), .refillWritable(refillWritable), .faultValid(faultValid),
    .faultVaddr(faultVaddr), .faultIsWrite(faultIsWrite)
  );

  // Behavioural reference: phase 0 idle, 1 request, 2 awaiting data, 3 refill, 4 fault
  int          mPhase = 0;
  logic [31:0] mBase = '0;
  logic [31:0] mAddr = '0;
  logic [31:0] mPte = '0;
  logic [19:0] mVpn = '0;
  logic        mWr = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0;
      mBase  = 32'h0;
    end else begin
      case (mPhase)
        0: if (missValid) begin
             mVpn = missVpn;
             mWr = missIsWrite;
             mAddr = mBase + {missVpn, 2'b00};
             mPhase = 1;
           end
        1: if (memReqReady) mPhase = 2;
        2: if (memRspValid) begin
             mPte = memRspData;
             mPhase = memRspData[31] ? 3 : 4;
           end
        default: mPhase = 0;
      endcase
      if (baseWrEn && supervisor) mBase = baseWrData;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rstN) begin
      chk("R1 missReady in reset", 32'(missReady), 32'd1);
      chk("R1 memReqValid in reset", 32'(memReqValid), 32'd0);
    end else begin
      chk("R2/R9 missReady", 32'(missReady), 32'(mPhase == 0));
      chk("R3 memReqValid", 32'(memReqValid), 32'(mPhase == 1));
      if (mPhase == 1) chk("R3/R4/R5 memReqAddr", memReqAddr, mAddr);
      chk("R7/R10 refillValid", 32'(refillValid), 32'(mPhase == 3));
      chk("R8/R10 faultValid", 32'(faultValid), 32'(mPhase == 4));
      if (mPhase == 3) begin
        chk("R7 refillPpn", 32'(refillPpn), 32'(mPte[17:0]));
        chk("R7 refillWritable", 32'(refillWritable), 32'(mPte[30]));
        chk("R7/R2 refillVpn", 32'(refillVpn), 32'(mVpn));
      end
      if (mPhase == 4) begin
        chk("R8 faultVaddr", faultVaddr, {mVpn, 12'h000});
        chk("R8/R2 faultIsWrite", 32'(faultIsWrite), 32'(mWr));
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic setBase(input logic [31:0] val, input logic sup);
    baseWrEn = 1'b1; baseWrData = val; supervisor = sup;
    cyc();
    baseWrEn = 1'b0; supervisor = 1'b0;
  endtask

  // One walk: noise = foreign misses and early responses (R2, R6); midBase = base write during walk (R5)
  task automatic walk(input logic [19:0] vpn, input logic isWr, input logic [31:0] pte,
                      input int reqWait, input int rspWait, input bit noise, input bit midBase);
    missValid = 1'b1; missVpn = vpn; missIsWrite = isWr;
    cyc();
    missValid = noise; missVpn = ~vpn; missIsWrite = ~isWr;
    memRspValid = noise; memRspData = ~pte;
    if (midBase) begin
      baseWrEn = 1'b1; supervisor = 1'b1; baseWrData = $urandom;
    end
    repeat (reqWait) cyc();
    baseWrEn = 1'b0; supervisor = 1'b0;
    memRspValid = 1'b0;
    memReqReady = 1'b1;
    cyc();
    memReqReady = 1'b0;
    repeat (rspWait) cyc();
    memRspValid = 1'b1; memRspData = pte;
    cyc();
    memRspValid = 1'b0; missValid = 1'b0;
    cyc();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1: walk with reset base of zero
    walk(20'h00123, 1'b0, 32'h8000_0ABC, 0, 0, 0, 0);
    // R4: supervisor write accepted
    setBase(32'h0040_0000, 1'b1);
    walk(20'h00010, 1'b0, 32'hC003_FFFF, 2, 3, 0, 0);
    // R4: user write ignored
    setBase(32'hDEAD_0000, 1'b0);
    walk(20'h00011, 1'b1, 32'h8001_2345, 1, 1, 0, 0);
    // R8: invalid entry on a write
    walk(20'hABCDE, 1'b1, 32'h4002_0000, 0, 2, 0, 0);
    // R3: address wrap with all-ones page number
    setBase(32'hFFFF_F000, 1'b1);
    walk(20'hFFFFF, 1'b0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    // R2 and R6: foreign misses and early responses during the walk
    walk(20'h0F0F0, 1'b0, 32'h8000_1111, 4, 2, 1, 0);
    walk(20'h0F0F1, 1'b1, 32'h0000_2222, 3, 1, 1, 0);
    // R5: base changes while walking
    walk(20'h00777, 1'b0, 32'hC000_0777, 3, 0, 0, 1);
    walk(20'h00778, 1'b0, 32'h8000_0778, 0, 0, 0, 0);
    // R9: back-to-back walks, zero wait
    for (int i = 0; i < 4; i++)
      walk(20'(i * 3 + 1), i[0], {i[1], 1'b1, 30'(i * 7)}, 0, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 60; i++) begin
      if (($urandom % 4) == 0) setBase($urandom, 1'($urandom));
      walk(20'($urandom), 1'($urandom), $urandom, int'($urandom % 4), int'($urandom % 4),
           1'($urandom), 1'($urandom));
    end
    repeat (3) cyc();
    finishRun();
  end

endmodule